// File: doc/BRIEF.md
# Frame and Line Valid Timing Generator

This block produces the raster timing of a progressive-scan pixel stream in the pixel clock domain. It drives a frame strobe, a line strobe and a pixel qualifier, and it reports row and column coordinates. Software-style settings come in as plain inputs: output width and height, horizontal and vertical blank, shutter length in rows, row binning, dark column count, and four mode bits. The mode bits make dark rows and dark columns visible and select how the line strobe behaves outside the frame. The block computes the row length and the frame length from these settings. It scans a horizontal position counter and a vertical position counter across that raster, and it decodes the strobes from those two counters.

All settings are captured into an active copy when the scan starts and again at every frame boundary. The boundary is the clock that follows the last position of the last blanking row. A setting written partway through a frame therefore takes effect with the next frame. The outputs run freely and cannot be stalled: there is no ready input, and a consumer has to accept one position on every clock.

The timing constants are parameters: the per-bin row cost, the fixed row overhead, the blank base, the line offset, the dark row count and the vertical blank floor. A bench can shrink them to get short frames.

Top module: `fvlv_gen`

## Requirements
- R1: During reset and on the first clock after reset is released, `fv`, `lv` and `pix_valid` are 0, and `row_idx` and `col_idx` are 0. Scan position 0 appears on the outputs after the second rising edge that follows reset release.
- R2: The row length in clocks is T = 2·max(W/2 + max(HB, HBMIN), ROW_OVH + BIN_COST·(bin+1)), where HB = `cfg_hblank`+1, HBMIN = BIN_COST·(bin+1) + HBMIN_BASE + WDC/2, W = `cfg_width` and WDC = `cfg_dark_cols`.
- R3: A frame lasts H + max(VB, VBMIN) rows, where H = `cfg_height`, VB = `cfg_vblank`+1 and VBMIN = max(VB_FLOOR, SW−H)+1. SW is `cfg_shutter`, and SW−H counts as 0 when SW ≤ H.
- R4: `fv` is high during the first H rows of a frame (the rows with vertical index 0 to H−1), and it is high for whole rows only. When `cfg_show_dark_rows` is 1, `fv` is also high during the last DARK_ROWS rows of the frame. This makes `fv` rise earlier.
- R5: The line window covers horizontal index LV_OFS up to LV_OFS+W−1. When `cfg_show_dark_cols` is 1, the window opens WDC clocks earlier and its end does not move.
- R6: With both LV mode bits at 0, `lv` is high only when the position is in the line window and `fv` is high.
- R7: With `cfg_lv_cont` = 1, `lv` follows the line window in every row, including blanking rows, and the value of `cfg_lv_xor` has no effect.
- R8: With `cfg_lv_xor` = 1 and `cfg_lv_cont` = 0, `lv` equals `fv` XOR the line window.
- R9: `pix_valid` is high exactly when `fv` and `lv` are both high.
- R10: `row_idx` is 0 whenever `fv` is low and on the first row of `fv`. It then rises by 1 at the first clock of each following row while `fv` stays high.
- R11: `col_idx` is 0 outside the line window and at its first clock, and it rises by 1 on each later clock inside the window.
- R12: Settings are captured when the scan starts and at each frame boundary. A change made partway through a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 16 | Output image width W in pixels (even) |
| cfg_height | input | 16 | Output image height H in rows (at least 1) |
| cfg_hblank | input | 16 | Horizontal blank setting (HB = value+1) |
| cfg_vblank | input | 16 | Vertical blank setting (VB = value+1) |
| cfg_shutter | input | 16 | Shutter length in rows |
| cfg_row_bin | input | 2 | Row binning code (factor = code+1) |
| cfg_dark_cols | input | 8 | Dark column count WDC (no larger than LV_OFS) |
| cfg_show_dark_rows | input | 1 | Include dark rows inside `fv` |
| cfg_show_dark_cols | input | 1 | Open the line window early by WDC |
| cfg_lv_cont | input | 1 | Line strobe runs in every row |
| cfg_lv_xor | input | 1 | Line strobe is XOR of frame strobe and line window |
| fv | output | 1 | Frame valid strobe |
| lv | output | 1 | Line valid strobe |
| pix_valid | output | 1 | Pixel qualifier |
| row_idx | output | 16 | Row coordinate within `fv` |
| col_idx | output | 16 | Column coordinate within the line window |

## Verification
Scan position 0 of the first frame reaches the outputs after the second rising edge following reset release. The first edge captures the settings, and the output registers add one more edge. Every later position appears exactly one edge after the one before it. The scoreboard relies on this: it pushes one expected item per position, in raster order, before reset is released. It begins popping on the second edge and then pops one item per clock, sampling on the falling edge. For the mid-frame update case, the model switches to the new settings only at the frame boundary, so any early or late capture shows up as a mismatch in position.

// File: rtl/fvlv_pkg.sv
package fvlv_pkg;

  localparam int CNT_W  = 16;
  localparam int SUM_W  = 20;
  localparam int DCOL_W = 8;
  localparam int BIN_W  = 2;

  typedef enum logic [1:0] {
    LV_GATED = 2'd0,
    LV_FREE  = 2'd1,
    LV_XORED = 2'd2
  } lv_mode_e;

  typedef struct packed {
    logic [CNT_W-1:0]  width;
    logic [CNT_W-1:0]  height;
    logic [CNT_W-1:0]  hblank;
    logic [CNT_W-1:0]  vblank;
    logic [CNT_W-1:0]  shutter;
    logic [BIN_W-1:0]  row_bin;
    logic [DCOL_W-1:0] dark_cols;
    logic              show_rows;
    logic              show_cols;
    logic              lv_cont;
    logic              lv_xor;
  } scan_cfg_t;

  function automatic logic [SUM_W-1:0] umax(input logic [SUM_W-1:0] a,
                                            input logic [SUM_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fvlv_limits.sv
module fvlv_limits
  import fvlv_pkg::*;
#(
  parameter int BIN_COST   = 346,
  parameter int ROW_OVH    = 140,
  parameter int HBMIN_BASE = 64,
  parameter int LV_OFS     = 609,
  parameter int DARK_ROWS  = 8,
  parameter int VB_FLOOR   = 8
) (
  input  scan_cfg_t        cfg,
  output logic [SUM_W-1:0] row_len,
  output logic [SUM_W-1:0] frame_rows,
  output logic [SUM_W-1:0] act_rows,
  output logic [SUM_W-1:0] dark_first,
  output logic [SUM_W-1:0] lv_start,
  output logic [SUM_W-1:0] lv_end,
  output logic             show_dark,
  output lv_mode_e         mode
);

  localparam logic [SUM_W-1:0] ONE   = SUM_W'(1);
  localparam logic [SUM_W-1:0] K_BIN = SUM_W'(BIN_COST);
  localparam logic [SUM_W-1:0] K_OVH = SUM_W'(ROW_OVH);
  localparam logic [SUM_W-1:0] K_HBB = SUM_W'(HBMIN_BASE);
  localparam logic [SUM_W-1:0] K_LVO = SUM_W'(LV_OFS);
  localparam logic [SUM_W-1:0] K_DR  = SUM_W'(DARK_ROWS);
  localparam logic [SUM_W-1:0] K_VBF = SUM_W'(VB_FLOOR);

  logic [SUM_W-1:0] bin_f, bin_cost, hb_min, hb_eff, half_row, row_floor;
  logic [SUM_W-1:0] vb_eff, sw_over, vb_min, wpix, hpix, wdc;

  always_comb begin
    wpix      = SUM_W'(cfg.width);
    hpix      = SUM_W'(cfg.height);
    wdc       = SUM_W'(cfg.dark_cols);
    bin_f     = SUM_W'(cfg.row_bin) + ONE;
    bin_cost  = K_BIN * bin_f;
    // horizontal: two competing lower bounds on the half row
    hb_min    = bin_cost + K_HBB + (wdc >> 1);
    hb_eff    = SUM_W'(cfg.hblank) + ONE;
    half_row  = (wpix >> 1) + umax(hb_eff, hb_min);
    row_floor = K_OVH + bin_cost;
    row_len   = umax(half_row, row_floor) << 1;
    // vertical: shutter can stretch blanking past the programmed value
    vb_eff    = SUM_W'(cfg.vblank) + ONE;
    sw_over   = (cfg.shutter > cfg.height) ? (SUM_W'(cfg.shutter) - hpix) : '0;
    vb_min    = umax(K_VBF, sw_over) + ONE;
    frame_rows = hpix + umax(vb_eff, vb_min);
    act_rows   = hpix;
    dark_first = frame_rows - K_DR;
    show_dark  = cfg.show_rows;
    // line window: dark columns open it early, the end stays put
    lv_start   = K_LVO - (cfg.show_cols ? wdc : '0);
    lv_end     = K_LVO + wpix;
    if (cfg.lv_cont)     mode = LV_FREE;
    else if (cfg.lv_xor) mode = LV_XORED;
    else                 mode = LV_GATED;
  end

endmodule

// File: rtl/fvlv_scan_ctr.sv
module fvlv_scan_ctr
  import fvlv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  scan_cfg_t        cfg_in,
  input  logic [SUM_W-1:0] row_len,
  input  logic [SUM_W-1:0] frame_rows,
  output scan_cfg_t        cfg_act,
  output logic [SUM_W-1:0] hcnt,
  output logic [SUM_W-1:0] vcnt,
  output logic             run
);

  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  logic row_last, frame_last;

  assign row_last   = (hcnt == row_len - ONE);
  assign frame_last = (vcnt == frame_rows - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
      cfg_act <= '0;
    end else if (!run) begin
      run     <= 1'b1;
      cfg_act <= cfg_in;
    end else if (row_last) begin
      hcnt <= '0;
      if (frame_last) begin
        vcnt    <= '0;
        cfg_act <= cfg_in;
      end else begin
        vcnt <= vcnt + ONE;
      end
    end else begin
      hcnt <= hcnt + ONE;
    end
  end

endmodule

// File: rtl/fvlv_strobe.sv
module fvlv_strobe
  import fvlv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SUM_W-1:0] hcnt,
  input  logic [SUM_W-1:0] vcnt,
  input  logic [SUM_W-1:0] act_rows,
  input  logic [SUM_W-1:0] dark_first,
  input  logic [SUM_W-1:0] lv_start,
  input  logic [SUM_W-1:0] lv_end,
  input  logic             show_dark,
  input  lv_mode_e         mode,
  output logic             fv,
  output logic             lv,
  output logic             pix_valid,
  output logic [CNT_W-1:0] row_idx,
  output logic [CNT_W-1:0] col_idx
);

  logic             fv_d, win_d, lv_d;
  logic [CNT_W-1:0] row_d, col_d;

  always_comb begin
    fv_d  = run && ((vcnt < act_rows) || (show_dark && (vcnt >= dark_first)));
    win_d = run && (hcnt >= lv_start) && (hcnt < lv_end);
    case (mode)
      LV_FREE:  lv_d = win_d;
      LV_XORED: lv_d = fv_d ^ win_d;
      default:  lv_d = fv_d & win_d;
    endcase
    if (!fv_d || !fv)        row_d = '0;
    else if (hcnt == '0)     row_d = row_idx + CNT_W'(1);
    else                     row_d = row_idx;
    if (!win_d)              col_d = '0;
    else if (hcnt == lv_start) col_d = '0;
    else                     col_d = col_idx + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv        <= 1'b0;
      lv        <= 1'b0;
      pix_valid <= 1'b0;
      row_idx   <= '0;
      col_idx   <= '0;
    end else begin
      fv        <= fv_d;
      lv        <= lv_d;
      pix_valid <= fv_d & lv_d;
      row_idx   <= row_d;
      col_idx   <= col_d;
    end
  end

endmodule

// File: rtl/fvlv_gen.sv
module fvlv_gen
  import fvlv_pkg::*;
#(
  parameter int BIN_COST   = 346,
  parameter int ROW_OVH    = 140,
  parameter int HBMIN_BASE = 64,
  parameter int LV_OFS     = 609,
  parameter int DARK_ROWS  = 8,
  parameter int VB_FLOOR   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic [CNT_W-1:0]  cfg_height,
  input  logic [CNT_W-1:0]  cfg_hblank,
  input  logic [CNT_W-1:0]  cfg_vblank,
  input  logic [CNT_W-1:0]  cfg_shutter,
  input  logic [BIN_W-1:0]  cfg_row_bin,
  input  logic [DCOL_W-1:0] cfg_dark_cols,
  input  logic              cfg_show_dark_rows,
  input  logic              cfg_show_dark_cols,
  input  logic              cfg_lv_cont,
  input  logic              cfg_lv_xor,
  output logic              fv,
  output logic              lv,
  output logic              pix_valid,
  output logic [CNT_W-1:0]  row_idx,
  output logic [CNT_W-1:0]  col_idx
);

  scan_cfg_t        cfg_in, cfg_act;
  logic [SUM_W-1:0] row_len, frame_rows, act_rows, dark_first, lv_start, lv_end;
  logic [SUM_W-1:0] hcnt, vcnt;
  logic             show_dark, run;
  lv_mode_e         act_mode;

  always_comb begin
    cfg_in.width     = cfg_width;
    cfg_in.height    = cfg_height;
    cfg_in.hblank    = cfg_hblank;
    cfg_in.vblank    = cfg_vblank;
    cfg_in.shutter   = cfg_shutter;
    cfg_in.row_bin   = cfg_row_bin;
    cfg_in.dark_cols = cfg_dark_cols;
    cfg_in.show_rows = cfg_show_dark_rows;
    cfg_in.show_cols = cfg_show_dark_cols;
    cfg_in.lv_cont   = cfg_lv_cont;
    cfg_in.lv_xor    = cfg_lv_xor;
  end

  fvlv_scan_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_in     (cfg_in),
    .row_len    (row_len),
    .frame_rows (frame_rows),
    .cfg_act    (cfg_act),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .run        (run)
  );

  fvlv_limits #(
    .BIN_COST   (BIN_COST),
    .ROW_OVH    (ROW_OVH),
    .HBMIN_BASE (HBMIN_BASE),
    .LV_OFS     (LV_OFS),
    .DARK_ROWS  (DARK_ROWS),
    .VB_FLOOR   (VB_FLOOR)
  ) u_lim (
    .cfg        (cfg_act),
    .row_len    (row_len),
    .frame_rows (frame_rows),
    .act_rows   (act_rows),
    .dark_first (dark_first),
    .lv_start   (lv_start),
    .lv_end     (lv_end),
    .show_dark  (show_dark),
    .mode       (act_mode)
  );

  fvlv_strobe u_strb (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .act_rows   (act_rows),
    .dark_first (dark_first),
    .lv_start   (lv_start),
    .lv_end     (lv_end),
    .show_dark  (show_dark),
    .mode       (act_mode),
    .fv         (fv),
    .lv         (lv),
    .pix_valid  (pix_valid),
    .row_idx    (row_idx),
    .col_idx    (col_idx)
  );

endmodule

// File: rtl/fvlv_gen_chk.sv
module fvlv_gen_chk
  import fvlv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fv,
  input logic             lv,
  input logic             pix_valid,
  input logic [CNT_W-1:0] row_idx,
  input logic [CNT_W-1:0] col_idx,
  input lv_mode_e         act_mode
);

  // R9
  a_r9_valid_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (fv && lv));

  // R9
  a_r9_both_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fv && lv) |-> pix_valid);

  // R6: a gated line strobe never shows outside the frame
  a_r6_gated_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == LV_GATED && $stable(act_mode) && !fv) |-> !lv);

  // R10
  a_r10_row_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !fv |-> (row_idx == '0));

  // R10
  a_r10_row_zero_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fv) |-> (row_idx == '0));

  // R10
  a_r10_row_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fv && $past(fv) && row_idx != $past(row_idx)) |-> (row_idx == $past(row_idx) + CNT_W'(1)));

  // R11
  a_r11_col_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (col_idx != '0) |-> (col_idx == $past(col_idx) + CNT_W'(1)));

endmodule

bind fvlv_gen fvlv_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fv        (fv),
  .lv        (lv),
  .pix_valid (pix_valid),
  .row_idx   (row_idx),
  .col_idx   (col_idx),
  .act_mode  (act_mode)
);

// File: tb/test_fvlv_gen.sv
module test_fvlv_gen;
  import fvlv_pkg::*;

  localparam int BIN_COST   = 20;
  localparam int ROW_OVH    = 10;
  localparam int HBMIN_BASE = 6;
  localparam int LV_OFS     = 30;
  localparam int DARK_ROWS  = 8;
  localparam int VB_FLOOR   = 8;

  typedef struct {
    logic       fv, lv, pv;
    int         row, col, v, h;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  scan_cfg_t cur = '0;
  logic fv, lv, pix_valid;
  logic [CNT_W-1:0] row_idx, col_idx;

  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  exp_t q[$];

  logic m_pfv;
  int   m_row, m_col;

  always #10 clk = ~clk;

  fvlv_gen #(
    .BIN_COST(BIN_COST), .ROW_OVH(ROW_OVH), .HBMIN_BASE(HBMIN_BASE),
    .LV_OFS(LV_OFS), .DARK_ROWS(DARK_ROWS), .VB_FLOOR(VB_FLOOR)
  ) i_fvlv_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_width(cur.width), .cfg_height(cur.height), .cfg_hblank(cur.hblank),
    .cfg_vblank(cur.vblank), .cfg_shutter(cur.shutter), .cfg_row_bin(cur.row_bin),
    .cfg_dark_cols(cur.dark_cols), .cfg_show_dark_rows(cur.show_rows),
    .cfg_show_dark_cols(cur.show_cols), .cfg_lv_cont(cur.lv_cont), .cfg_lv_xor(cur.lv_xor),
    .fv(fv), .lv(lv), .pix_valid(pix_valid), .row_idx(row_idx), .col_idx(col_idx)
  );

  function automatic scan_cfg_t mk(int w, int h, int hb, int vb, int sw, int rb, int wdc,
                                   bit sr, bit sc, bit lc, bit lx);
    scan_cfg_t c;
    c.width = CNT_W'(w); c.height = CNT_W'(h); c.hblank = CNT_W'(hb);
    c.vblank = CNT_W'(vb); c.shutter = CNT_W'(sw); c.row_bin = BIN_W'(rb);
    c.dark_cols = DCOL_W'(wdc); c.show_rows = sr; c.show_cols = sc;
    c.lv_cont = lc; c.lv_xor = lx;
    return c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // R2
  function automatic int row_period(scan_cfg_t c);
    int bf = int'(c.row_bin) + 1;
    int hbmin = BIN_COST * bf + HBMIN_BASE + int'(c.dark_cols) / 2;
    int half = int'(c.width) / 2 + imax(int'(c.hblank) + 1, hbmin);
    return 2 * imax(half, ROW_OVH + BIN_COST * bf);
  endfunction

  // R3
  function automatic int frame_len(scan_cfg_t c);
    int sw_over = (c.shutter > c.height) ? int'(c.shutter) - int'(c.height) : 0;
    int vbmin = imax(VB_FLOOR, sw_over) + 1;
    return int'(c.height) + imax(int'(c.vblank) + 1, vbmin);
  endfunction

  // driver: one expected item per raster position of one frame
  task automatic push_frame(scan_cfg_t c, string tag);
    int t = row_period(c);
    int f = frame_len(c);
    int ls = LV_OFS - (c.show_cols ? int'(c.dark_cols) : 0);
    int le = LV_OFS + int'(c.width);
    for (int v = 0; v < f; v++) begin
      for (int h = 0; h < t; h++) begin
        exp_t e;
        logic win;
        e.fv = (v < int'(c.height)) || (c.show_rows && v >= f - DARK_ROWS);
        win  = (h >= ls) && (h < le);
        if (c.lv_cont)     e.lv = win;
        else if (c.lv_xor) e.lv = e.fv ^ win;
        else               e.lv = e.fv & win;
        e.pv = e.fv & e.lv;
        if (!e.fv || !m_pfv) m_row = 0;
        else if (h == 0)     m_row = m_row + 1;
        m_pfv = e.fv;
        if (!win || h == ls) m_col = 0;
        else                 m_col = m_col + 1;
        e.row = m_row; e.col = m_col; e.v = v; e.h = h; e.tag = tag;
        q.push_back(e);
      end
    end
  endtask

  // monitor: pops and compares one item per clock
  always @(negedge clk) begin
    if (mon_en && q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (fv !== e.fv || lv !== e.lv || pix_valid !== e.pv ||
          int'(row_idx) != e.row || int'(col_idx) != e.col) begin
        errors++;
        $display("FAIL %s v=%0d h=%0d actual fv/lv/pv/row/col=%b/%b/%b/%0d/%0d expected %b/%b/%b/%0d/%0d",
                 e.tag, e.v, e.h, fv, lv, pix_valid, row_idx, col_idx,
                 e.fv, e.lv, e.pv, e.row, e.col);
      end
    end
  end

  task automatic check_idle(string tag);
    checks++;
    if (fv !== 1'b0 || lv !== 1'b0 || pix_valid !== 1'b0 || row_idx != '0 || col_idx != '0) begin
      errors++;
      $display("FAIL %s actual fv/lv/pv/row/col=%b/%b/%b/%0d/%0d expected 0/0/0/0/0",
               tag, fv, lv, pix_valid, row_idx, col_idx);
    end
  endtask

  task automatic run_case(scan_cfg_t a, int frames_a, scan_cfg_t b, int frames_b,
                          int change_after, string tag);
    @(negedge clk);
    rst_n = 1'b0;
    cur = a;
    m_pfv = 1'b0; m_row = 0; m_col = 0;
    for (int i = 0; i < frames_a; i++) push_frame(a, tag);
    for (int i = 0; i < frames_b; i++) push_frame(b, tag);
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_idle("R1 first clock");
    #1 mon_en = 1'b1;
    if (frames_b != 0) begin
      repeat (change_after) @(negedge clk);
      cur = b;
    end
    wait (q.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    scan_cfg_t base;
    base = mk(16, 3, 0, 0, 1, 0, 8, 0, 0, 0, 0);
    run_case(base, 2, base, 0, 0, "R2 R3 R4 R5 R6 R9 R10 R11 base");
    run_case(mk(16, 3, 59, 11, 20, 1, 8, 0, 0, 0, 0), 2, base, 0, 0,
             "R2 R3 wide hblank and shutter");
    run_case(mk(20, 4, 0, 0, 1, 3, 8, 1, 1, 1, 0), 2, base, 0, 0,
             "R4 R5 R7 R10 dark rows/cols continuous");
    run_case(mk(12, 2, 5, 2, 1, 0, 16, 0, 1, 0, 1), 2, base, 0, 0,
             "R8 R9 R11 xor with dark cols");
    run_case(mk(12, 2, 0, 0, 1, 0, 8, 1, 0, 1, 1), 2, base, 0, 0,
             "R7 continuous over xor");
    run_case(base, 1, mk(24, 5, 0, 3, 30, 1, 4, 1, 0, 0, 1), 1, 40,
             "R12 mid-frame update");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule